// File: doc/BRIEF.md
# Column-Interleaved MAU Request Distributor

This block sits in front of a motion-compensation reference cache that is split into four parallel datapath lanes. Each cycle it can take a group of up to four memory access unit (MAU) requests that lie in one row. A group has a slot valid mask plus a column and row address for each slot. Every request goes to the lane named by the two low bits of its MAU column. The lane receives the column with those two bits removed. Each lane has its own ordered queue and a registered valid/ready output port. A lane therefore hands on at most one 32-pixel MAU (8 pixels wide, 4 rows tall) per cycle.

The block can also generate requests itself. A region walker accepts a pixel rectangle of up to 23x23, given as start x, start y, width and height. It converts the rectangle into one request group per MAU row, from top to bottom, and signals completion with a single-cycle pulse. Queues take a group only as a whole: if any lane the group needs has no space, the group waits intact. Two requests that need the same lane are issued in different cycles.

Top module: `mau_fetch_distributor`

## Requirements
- R1: A request with MAU column c and row r appears on lane c[1:0] with lane column c>>2 and row r unchanged.
- R2: A group is written into the lane queues only in a cycle where every lane it needs has space. While any of those lanes is full, no part of the group reaches any lane and the direct group input is not ready.
- R3: When several pending slots map to the same lane, the lowest-numbered slot issues first and the others follow in later cycles, each in slot order. The input is not ready while such a group is still being split.
- R4: Each lane delivers its requests in the order they were issued to it. When its output is stalled, the lane holds its output.
- R5: For a region (x, y, w, h) in pixels, the walker requests MAU columns x>>3 through (x+w-1)>>3 for each MAU row from y>>2 through (y+h-1)>>2. Rows are handled top to bottom, one group per row.
- R6: A 23x23 region starting at pixel (7, 3) spans 4 MAU columns and 7 MAU rows. With all lanes ready, `rgn_done` goes high exactly 7 cycles after the clock edge that accepts the region.
- R7: `rgn_done` is a single-cycle pulse in the cycle after the last row group is taken. `rgn_ready` is low while a region is being walked.
- R8: While the walker is busy, `grp_ready` is low. A group and a region offered together while idle are both accepted on the same edge. On every lane, that group's requests come out ahead of the region's.
- R9: After reset, all `lane_valid` are 0, `rgn_done` is 0, and `grp_ready` and `rgn_ready` are 1.
- R10: Slots whose `grp_mask` bit is 0 produce no lane request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | Direct request group offered |
| grp_ready | output | 1 | Direct group accepted on this edge |
| grp_mask | input | 4 | Slot valid bits |
| grp_col | input | 4x8 | MAU column per slot |
| grp_row | input | 4x8 | MAU row per slot |
| rgn_valid | input | 1 | Region walk requested |
| rgn_ready | output | 1 | Walker idle and able to take a region |
| rgn_x | input | 11 | Region start pixel column |
| rgn_y | input | 10 | Region start pixel row |
| rgn_w | input | 5 | Region width in pixels, 1 to 23 |
| rgn_h | input | 5 | Region height in pixels, 1 to 23 |
| rgn_done | output | 1 | Pulse after the last row group is taken |
| lane_valid | output | 4 | Request present on each lane |
| lane_ready | input | 4 | Lane consumer accepts |
| lane_col | output | 4x6 | Lane-local MAU column |
| lane_row | output | 4x8 | MAU row |

## Verification
A direct group and a region start can arrive in the same cycle. The bench provokes this by raising `grp_valid` and `rgn_valid` together while the block is idle. It then checks that both ready signals were high on that edge and that `grp_ready` drops on the next cycle while the walker runs. The per-lane output sequences show the outcome: on each lane, the direct group's MAUs must come before all of the region's row groups.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int DEF_LANE_BITS  = 2;
  localparam int DEF_COL_W      = 8;
  localparam int DEF_ROW_W      = 8;
  localparam int DEF_MAU_W_LOG  = 3;
  localparam int DEF_MAU_H_LOG  = 2;
  localparam int DEF_SZ_W       = 5;
  localparam int DEF_FIFO_DEPTH = 8;
endpackage

// File: rtl/mfd_lane_fifo.sv
module mfd_lane_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic         space,
  output logic         o_valid,
  input  logic         o_ready,
  output logic [W-1:0] o_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  assign pop   = (cnt != '0) && (!o_valid || o_ready);
  assign space = (cnt < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) o_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      o_valid <= 1'b0;
    end else begin
      if (wr)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(wr) - CW'(pop);
      if (pop)          o_valid <= 1'b1;
      else if (o_ready) o_valid <= 1'b0;
    end
  end

  // R4: the issuer never writes into a full queue
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr |-> space);

  // R4: a stalled output holds its request
  a_r4_hold_output: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
endmodule

// File: rtl/mfd_region_walker.sv
module mfd_region_walker #(
  parameter int LANE_BITS = 2,
  parameter int COL_W     = 8,
  parameter int ROW_W     = 8,
  parameter int MAU_W_LOG = 3,
  parameter int MAU_H_LOG = 2,
  parameter int SZ_W      = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               rgn_valid,
  output logic                               rgn_ready,
  input  logic [COL_W+MAU_W_LOG-1:0]         rgn_x,
  input  logic [ROW_W+MAU_H_LOG-1:0]         rgn_y,
  input  logic [SZ_W-1:0]                    rgn_w,
  input  logic [SZ_W-1:0]                    rgn_h,
  output logic                               g_valid,
  input  logic                               g_ready,
  output logic [(1<<LANE_BITS)-1:0]          g_mask,
  output logic [(1<<LANE_BITS)-1:0][COL_W-1:0] g_col,
  output logic [(1<<LANE_BITS)-1:0][ROW_W-1:0] g_row,
  output logic                               done
);
  localparam int SLOTS  = 1 << LANE_BITS;
  localparam int PX_W   = COL_W + MAU_W_LOG;
  localparam int PY_W   = ROW_W + MAU_H_LOG;
  localparam int SPAN_W = LANE_BITS + 1;

  logic              busy;
  logic [COL_W-1:0]  col0;
  logic [SPAN_W-1:0] ncols;
  logic [ROW_W-1:0]  row, last_row;
  logic [PX_W-1:0]   x_end;
  logic [PY_W-1:0]   y_end;
  logic [COL_W-1:0]  c_first, c_last;
  logic [ROW_W-1:0]  r_first, r_last;
  logic              take;

  assign x_end   = rgn_x + PX_W'(rgn_w) - PX_W'(1);
  assign y_end   = rgn_y + PY_W'(rgn_h) - PY_W'(1);
  assign c_first = COL_W'(rgn_x >> MAU_W_LOG);
  assign c_last  = COL_W'(x_end >> MAU_W_LOG);
  assign r_first = ROW_W'(rgn_y >> MAU_H_LOG);
  assign r_last  = ROW_W'(y_end >> MAU_H_LOG);

  assign rgn_ready = !busy;
  assign g_valid   = busy;
  assign take      = busy && g_ready;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign g_mask[s] = busy && (SPAN_W'(s) < ncols);
      assign g_col[s]  = col0 + COL_W'(s);
      assign g_row[s]  = row;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      col0     <= '0;
      ncols    <= '0;
      row      <= '0;
      last_row <= '0;
    end else begin
      done <= take && (row == last_row);
      if (!busy && rgn_valid) begin
        busy     <= 1'b1;
        col0     <= c_first;
        ncols    <= SPAN_W'(c_last - c_first) + SPAN_W'(1);
        row      <= r_first;
        last_row <= r_last;
      end else if (take) begin
        if (row == last_row) busy <= 1'b0;
        else                 row  <= row + ROW_W'(1);
      end
    end
  end

  // R7: completion is a one-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: completion follows the end of a busy walk
  a_r7_done_after_walk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R5: the walk never passes the last row
  a_r5_row_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (row <= last_row));
endmodule

// File: rtl/mfd_group_issuer.sv
module mfd_group_issuer #(
  parameter int LANE_BITS = 2,
  parameter int COL_W     = 8,
  parameter int ROW_W     = 8
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            in_valid,
  output logic                                            in_ready,
  input  logic [(1<<LANE_BITS)-1:0]                       in_mask,
  input  logic [(1<<LANE_BITS)-1:0][COL_W-1:0]            in_col,
  input  logic [(1<<LANE_BITS)-1:0][ROW_W-1:0]            in_row,
  input  logic [(1<<LANE_BITS)-1:0]                       lane_space,
  output logic [(1<<LANE_BITS)-1:0]                       lane_wr,
  output logic [(1<<LANE_BITS)-1:0][COL_W-LANE_BITS-1:0]  lane_col,
  output logic [(1<<LANE_BITS)-1:0][ROW_W-1:0]            lane_row
);
  localparam int LANES  = 1 << LANE_BITS;
  localparam int SLOTS  = LANES;
  localparam int LCOL_W = COL_W - LANE_BITS;

  logic [SLOTS-1:0]             pend_mask;
  logic [SLOTS-1:0][COL_W-1:0]  pend_col;
  logic [SLOTS-1:0][ROW_W-1:0]  pend_row;

  logic [LANES-1:0][SLOTS-1:0]  hit, pick;
  logic [LANES-1:0]             tgt;
  logic [SLOTS-1:0]             sel, clr;
  logic                         fire;

  always_comb begin
    sel      = '0;
    hit      = '0;
    pick     = '0;
    tgt      = '0;
    lane_col = '0;
    lane_row = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int s = 0; s < SLOTS; s++) begin
        hit[l][s]  = pend_mask[s] && (pend_col[s][LANE_BITS-1:0] == LANE_BITS'(l));
        pick[l][s] = hit[l][s] && !tgt[l];
        tgt[l]     = tgt[l] | hit[l][s];
        if (pick[l][s]) begin
          lane_col[l] = pend_col[s][COL_W-1:LANE_BITS];
          lane_row[l] = pend_row[s];
          sel[s]      = 1'b1;
        end
      end
    end
  end

  assign fire     = (tgt != '0) && ((tgt & ~lane_space) == '0);
  assign lane_wr  = fire ? tgt : '0;
  assign clr      = fire ? sel : '0;
  assign in_ready = ((pend_mask & ~clr) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mask <= '0;
      pend_col  <= '0;
      pend_row  <= '0;
    end else if (in_valid && in_ready) begin
      pend_mask <= in_mask;
      pend_col  <= in_col;
      pend_row  <= in_row;
    end else begin
      pend_mask <= pend_mask & ~clr;
    end
  end

  // R2: a blocked group keeps every pending slot
  a_r2_group_held: assert property (@(posedge clk) disable iff (rst)
    ((pend_mask != '0) && !fire) |=> $stable(pend_mask));

  // R10: with no pending slot nothing is written to a lane
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    (pend_mask == '0) |-> (lane_wr == '0));

  // R3: only slots that were pending can be issued
  a_r3_issue_subset: assert property (@(posedge clk) disable iff (rst)
    ((sel & ~pend_mask) == '0));

  localparam int LCOL_UNUSED = LCOL_W;
endmodule

// File: rtl/mau_fetch_distributor.sv
module mau_fetch_distributor
  import mfd_pkg::*;
#(
  parameter int LANE_BITS  = DEF_LANE_BITS,
  parameter int COL_W      = DEF_COL_W,
  parameter int ROW_W      = DEF_ROW_W,
  parameter int MAU_W_LOG  = DEF_MAU_W_LOG,
  parameter int MAU_H_LOG  = DEF_MAU_H_LOG,
  parameter int SZ_W       = DEF_SZ_W,
  parameter int FIFO_DEPTH = DEF_FIFO_DEPTH
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            grp_valid,
  output logic                                            grp_ready,
  input  logic [(1<<LANE_BITS)-1:0]                       grp_mask,
  input  logic [(1<<LANE_BITS)-1:0][COL_W-1:0]            grp_col,
  input  logic [(1<<LANE_BITS)-1:0][ROW_W-1:0]            grp_row,
  input  logic                                            rgn_valid,
  output logic                                            rgn_ready,
  input  logic [COL_W+MAU_W_LOG-1:0]                      rgn_x,
  input  logic [ROW_W+MAU_H_LOG-1:0]                      rgn_y,
  input  logic [SZ_W-1:0]                                 rgn_w,
  input  logic [SZ_W-1:0]                                 rgn_h,
  output logic                                            rgn_done,
  output logic [(1<<LANE_BITS)-1:0]                       lane_valid,
  input  logic [(1<<LANE_BITS)-1:0]                       lane_ready,
  output logic [(1<<LANE_BITS)-1:0][COL_W-LANE_BITS-1:0]  lane_col,
  output logic [(1<<LANE_BITS)-1:0][ROW_W-1:0]            lane_row
);
  localparam int LANES  = 1 << LANE_BITS;
  localparam int SLOTS  = LANES;
  localparam int LCOL_W = COL_W - LANE_BITS;
  localparam int ENT_W  = LCOL_W + ROW_W;

  logic                          wk_valid;
  logic [SLOTS-1:0]              wk_mask;
  logic [SLOTS-1:0][COL_W-1:0]   wk_col;
  logic [SLOTS-1:0][ROW_W-1:0]   wk_row;

  logic                          iss_valid, iss_ready;
  logic [SLOTS-1:0]              iss_mask;
  logic [SLOTS-1:0][COL_W-1:0]   iss_col;
  logic [SLOTS-1:0][ROW_W-1:0]   iss_row;

  logic [LANES-1:0]              q_space, q_wr;
  logic [LANES-1:0][LCOL_W-1:0]  q_col;
  logic [LANES-1:0][ROW_W-1:0]   q_row;

  mfd_region_walker #(
    .LANE_BITS(LANE_BITS), .COL_W(COL_W), .ROW_W(ROW_W),
    .MAU_W_LOG(MAU_W_LOG), .MAU_H_LOG(MAU_H_LOG), .SZ_W(SZ_W)
  ) u_walker (
    .clk(clk), .rst(rst),
    .rgn_valid(rgn_valid), .rgn_ready(rgn_ready),
    .rgn_x(rgn_x), .rgn_y(rgn_y), .rgn_w(rgn_w), .rgn_h(rgn_h),
    .g_valid(wk_valid), .g_ready(iss_ready),
    .g_mask(wk_mask), .g_col(wk_col), .g_row(wk_row),
    .done(rgn_done)
  );

  // The walker owns the issuer while it runs; direct groups wait.
  assign iss_valid = wk_valid || grp_valid;
  assign iss_mask  = wk_valid ? wk_mask : grp_mask;
  assign iss_col   = wk_valid ? wk_col  : grp_col;
  assign iss_row   = wk_valid ? wk_row  : grp_row;
  assign grp_ready = iss_ready && !wk_valid;

  mfd_group_issuer #(
    .LANE_BITS(LANE_BITS), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_issuer (
    .clk(clk), .rst(rst),
    .in_valid(iss_valid), .in_ready(iss_ready),
    .in_mask(iss_mask), .in_col(iss_col), .in_row(iss_row),
    .lane_space(q_space), .lane_wr(q_wr),
    .lane_col(q_col), .lane_row(q_row)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [ENT_W-1:0] q_out;
      mfd_lane_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr(q_wr[l]), .din({q_col[l], q_row[l]}), .space(q_space[l]),
        .o_valid(lane_valid[l]), .o_ready(lane_ready[l]), .o_data(q_out)
      );
      assign lane_col[l] = q_out[ENT_W-1:ROW_W];
      assign lane_row[l] = q_out[ROW_W-1:0];
    end
  endgenerate

  // R8: a direct group is never taken while a region is walked
  a_r8_region_first: assert property (@(posedge clk) disable iff (rst)
    (!rgn_ready) |-> !grp_ready);
endmodule

// File: tb/mau_fetch_distributor_test.sv
`timescale 1ns/1ps
module mau_fetch_distributor_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            grp_valid = 1'b0;
  logic            grp_ready;
  logic [3:0]      grp_mask = '0;
  logic [3:0][7:0] grp_col = '0;
  logic [3:0][7:0] grp_row = '0;
  logic            rgn_valid = 1'b0;
  logic            rgn_ready;
  logic [10:0]     rgn_x = '0;
  logic [9:0]      rgn_y = '0;
  logic [4:0]      rgn_w = '0;
  logic [4:0]      rgn_h = '0;
  logic            rgn_done;
  logic [3:0]      lane_valid;
  logic [3:0]      lane_ready = 4'hF;
  logic [3:0][5:0] lane_col;
  logic [3:0][7:0] lane_row;

  mau_fetch_distributor uut (
    .clk(clk), .rst(rst),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_mask(grp_mask),
    .grp_col(grp_col), .grp_row(grp_row),
    .rgn_valid(rgn_valid), .rgn_ready(rgn_ready),
    .rgn_x(rgn_x), .rgn_y(rgn_y), .rgn_w(rgn_w), .rgn_h(rgn_h),
    .rgn_done(rgn_done),
    .lane_valid(lane_valid), .lane_ready(lane_ready),
    .lane_col(lane_col), .lane_row(lane_row)
  );

  int checks = 0;
  int fails  = 0;
  logic [13:0] got_q [4][$];
  logic [13:0] exp_q [4][$];

  always @(negedge clk) begin
    if (!rst)
      for (int l = 0; l < 4; l++)
        if (lane_valid[l] && lane_ready[l])
          got_q[l].push_back({lane_col[l], lane_row[l]});
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_q();
    for (int l = 0; l < 4; l++) begin
      got_q[l].delete();
      exp_q[l].delete();
    end
  endtask

  task automatic exp_add(input int c, input int r);
    exp_q[c & 3].push_back({6'(c >> 2), 8'(r)});
  endtask

  task automatic exp_region(input int x, input int y, input int w, input int h);
    for (int r = y >> 2; r <= (y + h - 1) >> 2; r++)
      for (int c = x >> 3; c <= (x + w - 1) >> 3; c++)
        exp_add(c, r);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_lanes(input string req);
    for (int l = 0; l < 4; l++) begin
      bit ok = (got_q[l].size() == exp_q[l].size());
      int bad_g = got_q[l].size();
      int bad_e = exp_q[l].size();
      if (ok)
        for (int i = 0; i < got_q[l].size(); i++)
          if (ok && got_q[l][i] != exp_q[l][i]) begin
            ok = 1'b0;
            bad_g = int'(got_q[l][i]);
            bad_e = int'(exp_q[l][i]);
          end
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s lane %0d: actual %0d expected %0d (entry or count)", req, l, bad_g, bad_e);
      end
    end
  endtask

  task automatic send_group(input logic [3:0] m, input logic [3:0][7:0] c,
                            input logic [3:0][7:0] r);
    grp_mask = m; grp_col = c; grp_row = r; grp_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (grp_ready) break;
    end
    @(posedge clk); #1;
    grp_valid = 1'b0;
  endtask

  task automatic start_region(input int x, input int y, input int w, input int h);
    rgn_x = 11'(x); rgn_y = 10'(y); rgn_w = 5'(w); rgn_h = 5'(h); rgn_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (rgn_ready) break;
    end
    @(posedge clk); #1;
    rgn_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 lane_valid", lane_valid == 4'h0, int'(lane_valid), 0);
    check("R9 rgn_done", rgn_done == 1'b0, int'(rgn_done), 0);
    check("R9 grp_ready", grp_ready == 1'b1, int'(grp_ready), 1);
    check("R9 rgn_ready", rgn_ready == 1'b1, int'(rgn_ready), 1);
  endtask

  task automatic t_routing();
    clear_q();
    send_group(4'hF, {8'd8, 8'd7, 8'd6, 8'd5}, {8'd3, 8'd3, 8'd3, 8'd3});
    exp_add(5, 3); exp_add(6, 3); exp_add(7, 3); exp_add(8, 3);
    settle(20);
    check_lanes("R1 routing");
  endtask

  task automatic t_sparse();
    clear_q();
    send_group(4'b0101, {8'd15, 8'd14, 8'd13, 8'd9}, {8'd7, 8'd6, 8'd5, 8'd4});
    exp_add(9, 4); exp_add(14, 6);
    settle(20);
    check_lanes("R10 masked slots");
  endtask

  task automatic t_conflict();
    clear_q();
    send_group(4'hF, {8'd1, 8'd12, 8'd8, 8'd4}, {8'd2, 8'd2, 8'd2, 8'd2});
    @(negedge clk);
    check("R3 input held during split", grp_ready == 1'b0, int'(grp_ready), 0);
    exp_add(4, 2); exp_add(8, 2); exp_add(12, 2); exp_add(1, 2);
    settle(20);
    check_lanes("R3 same-lane order");
  endtask

  task automatic t_backpressure();
    bit l1_quiet = 1'b1;
    clear_q();
    lane_ready = 4'b1110;
    for (int i = 0; i < 9; i++) begin
      send_group(4'b0001, {24'd0, 8'(4 * i)}, {24'd0, 8'd0});
      exp_add(4 * i, 0);
    end
    send_group(4'b0011, {16'd0, 8'd1, 8'd36}, {16'd0, 8'd1, 8'd1});
    exp_add(36, 1); exp_add(1, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (lane_valid[1]) l1_quiet = 1'b0;
    end
    check("R2 lane1 held while lane0 full", l1_quiet, int'(!l1_quiet), 0);
    check("R2 input not ready", grp_ready == 1'b0, int'(grp_ready), 0);
    @(posedge clk); #1;
    lane_ready = 4'hF;
    settle(30);
    check_lanes("R4 per-lane order");
  endtask

  task automatic t_region();
    bit seen = 1'b0;
    clear_q();
    start_region(13, 6, 10, 5);
    exp_region(13, 6, 10, 5);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rgn_done) seen = 1'b1;
    end
    check("R7 done seen", seen, int'(seen), 1);
    settle(10);
    check_lanes("R5 region walk");
  endtask

  task automatic t_worst_region();
    int cnt = 0;
    bit ready_low = 1'b0;
    clear_q();
    start_region(7, 3, 23, 23);
    exp_region(7, 3, 23, 23);
    while (cnt < 30) begin
      @(posedge clk); #1;
      cnt++;
      if (cnt == 3) ready_low = !rgn_ready;
      if (rgn_done) break;
    end
    check("R6 done latency", cnt == 7, cnt, 7);
    check("R7 rgn_ready low while busy", ready_low, int'(ready_low), 1);
    @(posedge clk); #1;
    check("R7 done single cycle", rgn_done == 1'b0, int'(rgn_done), 0);
    settle(20);
    check("R6 group count", exp_q[0].size() == 7, exp_q[0].size(), 7);
    check_lanes("R6 worst-case region");
  endtask

  task automatic t_simultaneous();
    bit both;
    clear_q();
    grp_mask = 4'hF; grp_col = {8'd23, 8'd22, 8'd21, 8'd20};
    grp_row = {8'd9, 8'd9, 8'd9, 8'd9}; grp_valid = 1'b1;
    rgn_x = 11'd0; rgn_y = 10'd0; rgn_w = 5'd8; rgn_h = 5'd12; rgn_valid = 1'b1;
    @(negedge clk);
    both = grp_ready && rgn_ready;
    @(posedge clk); #1;
    grp_valid = 1'b0; rgn_valid = 1'b0;
    check("R8 both accepted together", both, int'(both), 1);
    @(negedge clk);
    check("R8 grp_ready low while walking", grp_ready == 1'b0, int'(grp_ready), 0);
    exp_add(20, 9); exp_add(21, 9); exp_add(22, 9); exp_add(23, 9);
    exp_region(0, 0, 8, 12);
    settle(30);
    check_lanes("R8 group ahead of region");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    settle(2);
    t_routing();
    t_sparse();
    t_conflict();
    t_backpressure();
    t_region();
    t_worst_region();
    t_simultaneous();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule